// File: doc/BRIEF.md
# Interval Timer and Status Unit for an FM Synthesis Core

This block provides the pair of interval timers and the status byte of a classic FM synthesis core. A host writes a register index and a data byte with one strobe. Index 0x02 sets the start value of timer A, index 0x03 sets the start value of timer B, and index 0x04 is a shared control byte. Each timer has its own time base and is driven by a one-cycle microsecond tick pulse.

Each timer counts upward. When it passes its top value it raises a sticky overflow flag, unless the flag is masked. A read strobe captures the status byte, which reports both flags and a summary bit. Writes to any other index are left for the rest of the core, and the block says so on `wrTaken`. The `TWO_OP_VARIANT` parameter selects the variant whose status byte always carries binary 110 in its three low bits.

Top module: `fm_timer_status`

## Requirements
- R1: A write to index 0x02 stores the 8-bit start value of timer A. A write to index 0x03 stores the 8-bit start value of timer B. A stopped timer takes up the stored value the next time it starts.
- R2: A write to index 0x04 with bit 7 clear does two things: bit 0 starts (1) or stops (0) timer A, and bit 1 does the same for timer B. A timer that was stopped and is now started reloads its counter from its start value and clears its step prescaler. A timer that is already running when a start bit arrives keeps counting and does not restart.
- R3: A running timer advances its count by one on every 80th tick (timer A) or every 320th tick (timer B). Counting from start value P, it overflows on the (256-P)*step-th tick. At overflow it reloads P and keeps running.
- R4: A write to index 0x04 with bit 7 set clears both overflow flags. Every other bit of that write is ignored, so run and mask states stay as they were.
- R5: Bit 6 of a control write with bit 7 clear sets the mask of timer A, and bit 5 sets the mask of timer B. Setting a mask clears that timer's flag at once. A masked timer keeps counting but never sets its flag.
- R6: An overflow flag stays set until it is cleared as in R4 or R5. Stopping a timer leaves its flag set.
- R7: The status byte has bit 6 equal to the timer A flag and bit 5 equal to the timer B flag. Bit 7 is set whenever bit 6 or bit 5 is set. Bits 4 and 3 are zero.
- R8: With `TWO_OP_VARIANT`=1 (the default), status bits 2..0 always read binary 110. With `TWO_OP_VARIANT`=0 they read 000.
- R9: `statusOut` is zero after reset. It captures the status byte at the clock edge where `rdEn` is high, and holds that value until the next read.
- R10: `wrTaken` is high during a write strobe to index 0x02, 0x03 or 0x04. A write to any other index leaves `wrTaken` low and changes no state of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 8 | Register index of the write |
| wrData | input | 8 | Data byte of the write |
| wrTaken | output | 1 | The write is consumed by this block |
| rdEn | input | 1 | Status read strobe |
| statusOut | output | 8 | Captured status byte |

## Verification
The counter and prescaler are hidden, so a wrong count shows up only at the next overflow. That overflow becomes visible in the status byte at the first read after it. The bench therefore reads the status one tick before each expected overflow and again on the tick of the overflow. This pins the overflow to an exact cycle in both time bases and for a non-maximal start value. A wrong mask, run or flag state changes bits 6, 5 and 7 at the first read after the control write that should have set it. The bench probes that read right after each such write, and again after further ticks to see whether a masked timer rises.

// File: rtl/fm_timer_pkg.sv
package fm_timer_pkg;
  localparam int NUM_TIMERS = 2;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] IDX_PRESET_A = 8'h02;
  localparam logic [DATA_W-1:0] IDX_PRESET_B = 8'h03;
  localparam logic [DATA_W-1:0] IDX_CONTROL  = 8'h04;

  localparam int BIT_CLEAR  = 7;
  localparam int BIT_MASK_A = 6;
  localparam int BIT_MASK_B = 5;
  localparam int BIT_RUN_A  = 0;
  localparam int BIT_RUN_B  = 1;

  typedef struct packed {
    logic [NUM_TIMERS-1:0] loadPreset;
    logic                  ctrlWr;
    logic                  clearAll;
    logic [NUM_TIMERS-1:0] runVal;
    logic [NUM_TIMERS-1:0] maskVal;
    logic [DATA_W-1:0]     data;
  } ctrl_strobes_t;
endpackage

// File: rtl/fm_timer_ctrl.sv
module fm_timer_ctrl
  import fm_timer_pkg::*;
(
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrTaken,
  output ctrl_strobes_t     strobes
);
  logic hitA, hitB, hitCtl;

  always_comb begin
    hitA   = wrEn && (wrIdx == IDX_PRESET_A);
    hitB   = wrEn && (wrIdx == IDX_PRESET_B);
    hitCtl = wrEn && (wrIdx == IDX_CONTROL);
    wrTaken = hitA | hitB | hitCtl;

    strobes            = '0;
    strobes.data       = wrData;
    strobes.loadPreset = {hitB, hitA};
    strobes.clearAll   = hitCtl & wrData[BIT_CLEAR];
    strobes.ctrlWr     = hitCtl & ~wrData[BIT_CLEAR];
    strobes.runVal     = {wrData[BIT_RUN_B], wrData[BIT_RUN_A]};
    strobes.maskVal    = {wrData[BIT_MASK_B], wrData[BIT_MASK_A]};
  end
endmodule

// File: rtl/fm_timer_chan.sv
module fm_timer_chan #(
  parameter int STEP_US = 80,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             loadPreset,
  input  logic [CNT_W-1:0] presetIn,
  input  logic             ctrlWr,
  input  logic             runIn,
  input  logic             maskIn,
  input  logic             clearAll,
  output logic             flagOut
);
  localparam int PRE_W = (STEP_US > 1) ? $clog2(STEP_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_US - 1);

  logic [CNT_W-1:0] presetQ, cntQ;
  logic [PRE_W-1:0] preQ;
  logic             runQ, maskQ, flagQ;
  logic             startNow, countEn, stepNow, wrapNow;

  always_comb begin
    startNow = ctrlWr & runIn & ~runQ;
    countEn  = runQ & usTick & ~(ctrlWr & ~runIn);
    stepNow  = countEn & (preQ == PRE_LAST);
    wrapNow  = stepNow & (cntQ == '1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presetQ <= '0;
      cntQ    <= '0;
      preQ    <= '0;
      runQ    <= 1'b0;
      maskQ   <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (loadPreset) presetQ <= presetIn;
      if (ctrlWr) begin
        runQ  <= runIn;
        maskQ <= maskIn;
      end
      if (startNow) begin
        cntQ <= presetQ;
        preQ <= '0;
      end else if (countEn) begin
        preQ <= stepNow ? '0 : preQ + 1'b1;
        if (stepNow) cntQ <= wrapNow ? presetQ : cntQ + 1'b1;
      end
      if (clearAll || (ctrlWr && maskIn)) flagQ <= 1'b0;
      else if (wrapNow && !maskQ)         flagQ <= 1'b1;
    end
  end

  assign flagOut = flagQ;
endmodule

// File: rtl/fm_timer_dp.sv
module fm_timer_dp
  import fm_timer_pkg::*;
#(
  parameter int STEP_A_US      = 80,
  parameter int STEP_B_US      = 320,
  parameter bit TWO_OP_VARIANT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  usTick,
  input  ctrl_strobes_t         strobes,
  input  logic                  rdEn,
  output logic [NUM_TIMERS-1:0] flags,
  output logic [DATA_W-1:0]     statusOut
);
  localparam logic [2:0] LOW_BITS = TWO_OP_VARIANT ? 3'b110 : 3'b000;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chan
    localparam int STEP = (t == 0) ? STEP_A_US : STEP_B_US;
    fm_timer_chan #(.STEP_US(STEP), .CNT_W(DATA_W)) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .usTick    (usTick),
      .loadPreset(strobes.loadPreset[t]),
      .presetIn  (strobes.data),
      .ctrlWr    (strobes.ctrlWr),
      .runIn     (strobes.runVal[t]),
      .maskIn    (strobes.maskVal[t]),
      .clearAll  (strobes.clearAll),
      .flagOut   (flags[t])
    );
  end

  logic [DATA_W-1:0] statusNow, statusQ;

  always_comb begin
    statusNow      = '0;
    statusNow[6]   = flags[0];
    statusNow[5]   = flags[1];
    statusNow[7]   = |flags;
    statusNow[2:0] = LOW_BITS;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     statusQ <= '0;
    else if (rdEn) statusQ <= statusNow;
  end

  assign statusOut = statusQ;
endmodule

// File: rtl/fm_timer_status.sv
module fm_timer_status
  import fm_timer_pkg::*;
#(
  parameter int STEP_A_US      = 80,
  parameter int STEP_B_US      = 320,
  parameter bit TWO_OP_VARIANT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       wrEn,
  input  logic [7:0] wrIdx,
  input  logic [7:0] wrData,
  output logic       wrTaken,
  input  logic       rdEn,
  output logic [7:0] statusOut
);
  ctrl_strobes_t         strobes;
  logic [NUM_TIMERS-1:0] timerFlags;

  fm_timer_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .wrTaken(wrTaken),
    .strobes(strobes)
  );

  fm_timer_dp #(
    .STEP_A_US     (STEP_A_US),
    .STEP_B_US     (STEP_B_US),
    .TWO_OP_VARIANT(TWO_OP_VARIANT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .strobes  (strobes),
    .rdEn     (rdEn),
    .flags    (timerFlags),
    .statusOut(statusOut)
  );
endmodule

// File: rtl/fm_timer_status_chk.sv
module fm_timer_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       usTick,
  input logic       wrEn,
  input logic [7:0] wrIdx,
  input logic [7:0] wrData,
  input logic       rdEn,
  input logic [7:0] statusOut,
  input logic [1:0] timerFlags
);
  // R3: a flag can only rise on a tick edge
  assert_flag_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerFlags[0]) |-> $past(usTick));

  // R4: a clear-all control write leaves both flags low
  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 8'h04 && wrData[7]) |=> (timerFlags == 2'b00));

  // R5: setting timer A's mask drops its flag
  assert_mask_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 8'h04 && !wrData[7] && wrData[6]) |=> !timerFlags[0]);

  // R6: a control write that neither clears nor masks keeps a set flag
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 8'h04 && !wrData[7] && !wrData[6] && timerFlags[0]) |=> timerFlags[0]);

  // R7: the summary bit follows the two flag bits
  assert_summary_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7] == (statusOut[6] | statusOut[5]));

  // R9: a read captures the flag state of the edge it lands on
  assert_read_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (statusOut[6] == $past(timerFlags[0]) && statusOut[5] == $past(timerFlags[1])));

  // R9: without a read the status byte holds
  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(statusOut));
endmodule

bind fm_timer_status fm_timer_status_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .usTick    (usTick),
  .wrEn      (wrEn),
  .wrIdx     (wrIdx),
  .wrData    (wrData),
  .rdEn      (rdEn),
  .statusOut (statusOut),
  .timerFlags(timerFlags)
);

// File: tb/fm_timer_status_tb.sv
module fm_timer_status_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrIdx = '0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic       wrTaken;
  logic [7:0] statusOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fm_timer_status u_dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .wrTaken(wrTaken), .rdEn(rdEn), .statusOut(statusOut)
  );

  // {index, data, ticks after the write, expected status, expected wrTaken}
  localparam int NV = 18;
  localparam logic [40:0] VEC [NV] = '{
    {8'h02, 8'hFF, 16'd0,   8'h06, 1'b1}, // R1 start value A
    {8'h03, 8'hFF, 16'd0,   8'h06, 1'b1}, // R1 start value B
    {8'h04, 8'h01, 16'd79,  8'h06, 1'b1}, // R2 start A, R3 one tick short
    {8'h10, 8'h00, 16'd1,   8'hC6, 1'b0}, // R3 A overflows, R10 foreign index
    {8'h04, 8'h00, 16'd0,   8'hC6, 1'b1}, // R6 stop keeps flag
    {8'h04, 8'h80, 16'd0,   8'h06, 1'b1}, // R4 clear all
    {8'h04, 8'h02, 16'd319, 8'h06, 1'b1}, // R3 B one tick short
    {8'h05, 8'h00, 16'd1,   8'hA6, 1'b0}, // R3 B overflows, R7 layout
    {8'h04, 8'h22, 16'd320, 8'h06, 1'b1}, // R5 mask B clears and suppresses
    {8'h04, 8'h03, 16'd80,  8'hC6, 1'b1}, // R2 restart A from stopped
    {8'h04, 8'h80, 16'd240, 8'hE6, 1'b1}, // R4 clear leaves both running
    {8'h04, 8'h43, 16'd0,   8'hA6, 1'b1}, // R5 mask A, B flag stays
    {8'h02, 8'hFE, 16'd0,   8'hA6, 1'b1}, // R1 new start value A
    {8'h04, 8'h80, 16'd0,   8'h06, 1'b1}, // R4
    {8'h04, 8'h00, 16'd0,   8'h06, 1'b1}, // R2 stop both
    {8'h04, 8'h01, 16'd159, 8'h06, 1'b1}, // R1 start value 0xFE -> 160 ticks
    {8'h04, 8'h01, 16'd1,   8'hC6, 1'b1}, // R2 start while running: no restart
    {8'hFF, 8'h80, 16'd0,   8'hC6, 1'b0}  // R10 clear bit on foreign index
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [7:0] dat, output logic taken);
    wrEn = 1'b1; wrIdx = idx; wrData = dat;
    #1 taken = wrTaken;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n);
    for (int k = 0; k < n; k++) begin
      usTick = 1'b1;
      @(negedge clk);
    end
    usTick = 1'b0;
  endtask

  task automatic readStatus(output logic [7:0] val);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    val = statusOut;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic       tk;
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset value", statusOut, 8'h00);
    readStatus(st);
    check("R8 low bits after reset", st, 8'h06);

    for (int v = 0; v < NV; v++) begin
      doWrite(VEC[v][40:33], VEC[v][32:25], tk);
      check($sformatf("R10 wrTaken vec%0d", v), {7'd0, tk}, {7'd0, VEC[v][0]});
      runTicks(int'(VEC[v][24:9]));
      readStatus(st);
      check($sformatf("R7 status vec%0d", v), st, VEC[v][8:1]);
    end

    // R9: status holds without a read, then a read updates it
    doWrite(8'h04, 8'h80, tk);
    runTicks(3);
    check("R9 hold without read", statusOut, 8'hC6);
    readStatus(st);
    check("R9 read after clear", st, 8'h06);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule